// File: doc/BRIEF.md
# Multi-Format Stereo Serial Audio Receiver

This block takes stereo audio from a three-wire serial link and turns it into parallel 18-bit words for the core. The three wires are a bit clock, a word clock that marks which channel is on the line, and serial data. All three are oversampled in the system clock domain. Each wire passes through a synchronizer of the same depth, so the relationship between bit-clock edges, word-clock level and data is kept. Data is sampled on every rising bit-clock edge.

A 2-bit format select chooses one of four framings: right-justified 16-bit, right-justified 18-bit, left-justified 18-bit, and I2S. In every framing the data is two's complement with the MSB first. Words shorter than 18 bits are placed in the upper bits and the two spare LSBs are zero. After a right-channel word completes a left/right pair, a one-cycle frame-ready strobe tells the core that both output words are fresh.

An active-low power-down input holds the block in reset, in the same way as the synchronous reset. After release, nothing is captured until the first rising word-clock edge. That edge starts the internal timing. The format select must not change while the block is powered up.

Top module: `aud_serial_rx`

## Requirements
- R1: While `rst` is high or `pwr_n` is low, `left_word` and `right_word` read 0 and `frame_rdy` stays low.
- R2: With `fmt_sel` = 2'b00 (right-justified 16-bit, at least 32 bit clocks per frame), the 16 bits sampled last before a word-clock transition form the word, placed in bits 17..2 with bits 1..0 zero. Any earlier bits in the half-frame have no effect.
- R3: With `fmt_sel` = 2'b01 (right-justified 18-bit, at least 36 bit clocks per frame), the 18 bits sampled last before a word-clock transition form the word. Earlier bits have no effect.
- R4: With `fmt_sel` = 2'b10 (left-justified 18-bit), the bit sampled at the first rising bit-clock edge after a word-clock transition is the MSB. The next 17 bits complete the word, and any later bits in the half-frame have no effect.
- R5: With `fmt_sel` = 2'b11 (I2S), the MSB is sampled one bit clock after the word-clock transition. The block works with 32 bit clocks per frame, where the LSB coincides with the next transition, and with 36 or more bit clocks per frame.
- R6: In the left-justified and I2S framings, a 16-bit word followed by two zero bits, or a 16-bit word alone in a 16-clock half-frame, yields the 16 bits in bits 17..2 and zeros in bits 1..0.
- R7: Channel selection by word-clock level: in formats 2'b00, 2'b01 and 2'b10, high means left; in format 2'b11, low means left.
- R8: `frame_rdy` pulses high for exactly one cycle, when a right word is written and a left word has been written since the previous pulse. At that cycle both outputs hold the pair.
- R9: After reset or power-down is released, word-clock transitions before the first rising word-clock edge capture nothing. The half-frame that the rising edge closes is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial link |
| rst | input | 1 | Synchronous active-high reset |
| pwr_n | input | 1 | Active-low power-down, holds the block in reset |
| fmt_sel | input | 2 | Framing select: 00 RJ16, 01 RJ18, 10 LJ18, 11 I2S |
| sclk_in | input | 1 | Serial bit clock |
| lrsel_in | input | 1 | Word clock, selects the channel on the line |
| sdat_in | input | 1 | Serial data, MSB first, two's complement |
| left_word | output | 18 | Last captured left-channel word |
| right_word | output | 18 | Last captured right-channel word |
| frame_rdy | output | 1 | One-cycle pulse when a left/right pair is complete |

## Verification
The right-justified framings are driven with half-frames longer than the word and filled with ones ahead of the data. A design that keeps early bits, or counts from the wrong end, shows up as corrupted upper bits. The left-justified framing gets trailing ones after the 18th bit, which separates a correct stop after 18 bits from a shifter that runs on. I2S is tried at 32 clocks per frame, where the LSB rides on the next word-clock edge, and at 48 clocks per frame; together with a padded 16-bit left-justified stream, this checks the one-bit delay and the zero padding. Distinct left and right values with negative extremes expose swapped channel polarity. A start sequence with the word clock already high catches capture before the first rising edge.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;
  typedef enum logic [1:0] {
    FMT_RJ16 = 2'b00,
    FMT_RJ18 = 2'b01,
    FMT_LJ18 = 2'b10,
    FMT_I2S  = 2'b11
  } fmt_e;
endpackage

// File: rtl/aud_rx_sync.sv
module aud_rx_sync #(
  parameter int STAGES = 2,
  parameter int W      = 3
) (
  input  logic         clk,
  input  logic         srst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (srst) stg[0] <= '0;
    else      stg[0] <= d;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (srst) stg[s] <= '0;
        else      stg[s] <= stg[s-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/aud_rx_frontend.sv
module aud_rx_frontend #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic srst,
  input  logic sclk_in,
  input  logic lrsel_in,
  input  logic sdat_in,
  output logic bit_stb,
  output logic lr_bit,
  output logic sd_bit
);
  logic [2:0] synced;
  logic       sclk_d;

  aud_rx_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
    .clk  (clk),
    .srst (srst),
    .d    ({sclk_in, lrsel_in, sdat_in}),
    .q    (synced)
  );

  always_ff @(posedge clk) begin
    if (srst) sclk_d <= 1'b0;
    else      sclk_d <= synced[2];
  end

  assign bit_stb = synced[2] & ~sclk_d;
  assign lr_bit  = synced[1];
  assign sd_bit  = synced[0];
endmodule

// File: rtl/aud_rx_deser.sv
module aud_rx_deser
  import aud_rx_pkg::*;
#(
  parameter int WORD_W  = 18,
  parameter int SHORT_W = 16
) (
  input  logic              clk,
  input  logic              srst,
  input  fmt_e              fmt,
  input  logic              bit_stb,
  input  logic              lr_bit,
  input  logic              sd_bit,
  output logic              cap_vld,
  output logic              cap_left,
  output logic [WORD_W-1:0] cap_word
);
  localparam int POS_W = $clog2(WORD_W + 1);
  localparam int PAD_W = WORD_W - SHORT_W;

  logic              seen, started, lr_prev;
  logic [WORD_W-1:0] shr, acc, acc_wr, sel_word;
  logic [POS_W-1:0]  pos;
  logic              chg, pos_open, prev_left, is_lj;

  assign chg       = seen && (lr_bit != lr_prev);
  assign pos_open  = pos < POS_W'(WORD_W);
  assign prev_left = (fmt == FMT_I2S) ? ~lr_prev : lr_prev;
  assign is_lj     = (fmt == FMT_LJ18);

  always_comb begin
    acc_wr = acc;
    for (int i = 0; i < WORD_W; i++) begin
      if (pos_open && (POS_W'(WORD_W - 1 - i) == pos)) acc_wr[i] = sd_bit;
    end
  end

  always_comb begin
    case (fmt)
      FMT_RJ16: sel_word = {shr[SHORT_W-1:0], {PAD_W{1'b0}}};
      FMT_RJ18: sel_word = shr;
      FMT_LJ18: sel_word = acc;
      default:  sel_word = acc_wr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (srst) begin
      seen     <= 1'b0;
      started  <= 1'b0;
      lr_prev  <= 1'b0;
      shr      <= '0;
      acc      <= '0;
      pos      <= '0;
      cap_vld  <= 1'b0;
      cap_left <= 1'b0;
      cap_word <= '0;
    end else begin
      cap_vld <= 1'b0;
      if (bit_stb) begin
        seen    <= 1'b1;
        lr_prev <= lr_bit;
        shr     <= {shr[WORD_W-2:0], sd_bit};
        if (chg && (started || lr_bit)) begin
          started <= 1'b1;
          if (started) begin
            cap_vld  <= 1'b1;
            cap_left <= prev_left;
            cap_word <= sel_word;
          end
          if (is_lj) begin
            acc <= {sd_bit, {(WORD_W-1){1'b0}}};
            pos <= POS_W'(1);
          end else begin
            acc <= '0;
            pos <= '0;
          end
        end else if (started && pos_open) begin
          acc <= acc_wr;
          pos <= pos + POS_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/aud_serial_rx.sv
module aud_serial_rx
  import aud_rx_pkg::*;
#(
  parameter int WORD_W      = 18,
  parameter int SHORT_W     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_n,
  input  logic [1:0]        fmt_sel,
  input  logic              sclk_in,
  input  logic              lrsel_in,
  input  logic              sdat_in,
  output logic [WORD_W-1:0] left_word,
  output logic [WORD_W-1:0] right_word,
  output logic              frame_rdy
);
  logic              srst;
  logic              bit_stb, lr_bit, sd_bit;
  logic              cap_vld, cap_left;
  logic [WORD_W-1:0] cap_word;
  logic              have_left;

  assign srst = rst | ~pwr_n;

  aud_rx_frontend #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk      (clk),
    .srst     (srst),
    .sclk_in  (sclk_in),
    .lrsel_in (lrsel_in),
    .sdat_in  (sdat_in),
    .bit_stb  (bit_stb),
    .lr_bit   (lr_bit),
    .sd_bit   (sd_bit)
  );

  aud_rx_deser #(.WORD_W(WORD_W), .SHORT_W(SHORT_W)) u_deser (
    .clk      (clk),
    .srst     (srst),
    .fmt      (fmt_e'(fmt_sel)),
    .bit_stb  (bit_stb),
    .lr_bit   (lr_bit),
    .sd_bit   (sd_bit),
    .cap_vld  (cap_vld),
    .cap_left (cap_left),
    .cap_word (cap_word)
  );

  always_ff @(posedge clk) begin
    if (srst) begin
      left_word  <= '0;
      right_word <= '0;
      frame_rdy  <= 1'b0;
      have_left  <= 1'b0;
    end else begin
      frame_rdy <= 1'b0;
      if (cap_vld) begin
        if (cap_left) begin
          left_word <= cap_word;
          have_left <= 1'b1;
        end else begin
          right_word <= cap_word;
          if (have_left) begin
            frame_rdy <= 1'b1;
            have_left <= 1'b0;
          end
        end
      end
    end
  end
endmodule

module aud_serial_rx_chk #(
  parameter int WORD_W = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              pwr_n,
  input logic [1:0]        fmt_sel,
  input logic              cap_vld,
  input logic              cap_left,
  input logic [WORD_W-1:0] cap_word,
  input logic [WORD_W-1:0] left_word,
  input logic [WORD_W-1:0] right_word,
  input logic              frame_rdy
);
  p_pd_clears_r1: assert property (@(posedge clk) disable iff (rst)
    !pwr_n |=> (left_word == '0 && right_word == '0 && !frame_rdy));

  p_rj16_pad_r2: assert property (@(posedge clk) disable iff (rst)
    (cap_vld && fmt_sel == 2'b00 && $stable(fmt_sel)) |-> (cap_word[1:0] == 2'b00));

  p_left_load_r7: assert property (@(posedge clk) disable iff (rst || !pwr_n)
    (cap_vld && cap_left) |=> (left_word == $past(cap_word)));

  p_strobe_single_r8: assert property (@(posedge clk) disable iff (rst)
    frame_rdy |=> !frame_rdy);

  p_strobe_on_right_r8: assert property (@(posedge clk) disable iff (rst)
    frame_rdy |-> $past(cap_vld && !cap_left));
endmodule

bind aud_serial_rx aud_serial_rx_chk #(.WORD_W(WORD_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pwr_n      (pwr_n),
  .fmt_sel    (fmt_sel),
  .cap_vld    (cap_vld),
  .cap_left   (cap_left),
  .cap_word   (cap_word),
  .left_word  (left_word),
  .right_word (right_word),
  .frame_rdy  (frame_rdy)
);

// File: tb/tb_aud_serial_rx.sv
`timescale 1ns/1ps
module tb_aud_serial_rx;
  localparam int HALF = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pwr_n = 1'b0;
  logic [1:0]  fmt_sel = 2'b00;
  logic        sclk_in = 1'b0;
  logic        lrsel_in = 1'b0;
  logic        sdat_in = 1'b0;
  logic [17:0] left_word, right_word;
  logic        frame_rdy;

  int checks = 0;
  int fails = 0;
  logic [17:0] cap_l [8];
  logic [17:0] cap_r [8];
  int cap_n = 0;
  logic rdy_prev = 1'b0;
  logic carry = 1'b1;

  always #10 clk = ~clk;

  aud_serial_rx dut (
    .clk(clk), .rst(rst), .pwr_n(pwr_n), .fmt_sel(fmt_sel),
    .sclk_in(sclk_in), .lrsel_in(lrsel_in), .sdat_in(sdat_in),
    .left_word(left_word), .right_word(right_word), .frame_rdy(frame_rdy)
  );

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (frame_rdy && rdy_prev) begin
      checks++; fails++;
      $display("FAIL R8 strobe wider than one cycle actual=1 expected=0");
    end
    if (frame_rdy && cap_n < 8) begin
      cap_l[cap_n] = left_word;
      cap_r[cap_n] = right_word;
      cap_n++;
    end
    rdy_prev = frame_rdy;
  end

  function automatic logic [17:0] keep_top(input logic [17:0] w, input int n);
    return (w >> (18 - n)) << (18 - n);
  endfunction

  task automatic drive_bit(input logic w, input logic d);
    @(negedge clk);
    lrsel_in = w; sdat_in = d;
    repeat (HALF) @(negedge clk);
    sclk_in = 1'b1;
    repeat (HALF) @(negedge clk);
    sclk_in = 1'b0;
  endtask

  task automatic send_slot(input logic [1:0] f, input logic w, input int slot, input int nsend,
                           input logic fill, input logic [17:0] word);
    logic c [32];
    for (int k = 0; k < slot; k++) begin
      if (f < 2'b10) c[k] = (k < slot - nsend) ? fill : word[17 - (k - (slot - nsend))];
      else           c[k] = (k < nsend) ? word[17 - k] : fill;
    end
    for (int k = 0; k < slot; k++) begin
      if (f == 2'b11) drive_bit(w, (k == 0) ? carry : c[k-1]);
      else            drive_bit(w, c[k]);
    end
    if (f == 2'b11) carry = c[slot-1];
  endtask

  task automatic restart(input logic [1:0] f, input logic lr0);
    @(negedge clk);
    pwr_n = 1'b0;
    fmt_sel = f; lrsel_in = lr0; sdat_in = 1'b0; sclk_in = 1'b0;
    repeat (3) @(negedge clk);
    check(left_word == 18'd0 && right_word == 18'd0 && !frame_rdy, "R1 power-down clears",
          {14'd0, left_word}, 32'd0);
    pwr_n = 1'b1;
    cap_n = 0;
    carry = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_case(input string req, input logic [1:0] f, input int slot, input int nsend,
                          input logic fill, input logic [17:0] l0, input logic [17:0] r0,
                          input logic [17:0] l1, input logic [17:0] r1);
    logic lh;
    lh = (f != 2'b11);
    restart(f, 1'b0);
    for (int k = 0; k < 3; k++) drive_bit(1'b0, 1'b1);
    if (!lh) send_slot(f, 1'b1, slot, nsend, fill, 18'h15555);
    send_slot(f, lh, slot, nsend, fill, l0);
    send_slot(f, !lh, slot, nsend, fill, r0);
    send_slot(f, lh, slot, nsend, fill, l1);
    send_slot(f, !lh, slot, nsend, fill, r1);
    send_slot(f, lh, 4, 0, 1'b1, 18'h0);
    repeat (20) @(negedge clk);
    check(cap_n == 2, {req, " frame count (R8)"}, cap_n, 2);
    check(cap_l[0] == keep_top(l0, nsend), {req, " left word 0 (R7)"}, {14'd0, cap_l[0]}, {14'd0, keep_top(l0, nsend)});
    check(cap_r[0] == keep_top(r0, nsend), {req, " right word 0 (R7)"}, {14'd0, cap_r[0]}, {14'd0, keep_top(r0, nsend)});
    check(cap_l[1] == keep_top(l1, nsend), {req, " left word 1"}, {14'd0, cap_l[1]}, {14'd0, keep_top(l1, nsend)});
    check(cap_r[1] == keep_top(r1, nsend), {req, " right word 1"}, {14'd0, cap_r[1]}, {14'd0, keep_top(r1, nsend)});
  endtask

  task automatic test_start_gate_r9();
    restart(2'b00, 1'b1);
    send_slot(2'b00, 1'b1, 24, 16, 1'b0, 18'h3A5A4);
    send_slot(2'b00, 1'b0, 24, 16, 1'b0, 18'h0C3C0);
    send_slot(2'b00, 1'b1, 24, 16, 1'b1, 18'h12344);
    send_slot(2'b00, 1'b0, 24, 16, 1'b1, 18'h2FEDC);
    send_slot(2'b00, 1'b1, 4, 0, 1'b1, 18'h0);
    repeat (20) @(negedge clk);
    check(cap_n == 1, "R9 frames before first rising edge", cap_n, 1);
    check(cap_l[0] == 18'h12344, "R9 left after start", {14'd0, cap_l[0]}, 32'h12344);
    check(cap_r[0] == 18'h2FEDC, "R9 right after start", {14'd0, cap_r[0]}, 32'h2FEDC);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(left_word == 18'd0 && right_word == 18'd0 && !frame_rdy, "R1 reset state",
          {14'd0, left_word}, 32'd0);
    rst = 1'b0;
    run_case("R2 rj16", 2'b00, 24, 16, 1'b1, 18'h2A5C4, 18'h1F0F0, 18'h20000, 18'h1FFFC);
    run_case("R3 rj18", 2'b01, 24, 18, 1'b1, 18'h20000, 18'h1FFFF, 18'h2A5C5, 18'h0F0F3);
    run_case("R4 lj18", 2'b10, 24, 18, 1'b1, 18'h12345, 18'h3FFFE, 18'h20001, 18'h0ABCD);
    run_case("R6 lj16 padded", 2'b10, 18, 16, 1'b0, 18'h3C3C3, 18'h1111F, 18'h20000, 18'h1FFFF);
    run_case("R5 R6 i2s 32fs", 2'b11, 16, 16, 1'b0, 18'h2468A, 18'h3579B, 18'h20003, 18'h1FFFF);
    run_case("R5 i2s 48fs", 2'b11, 24, 18, 1'b1, 18'h20001, 18'h1FFFE, 18'h2D2D2, 18'h12D2D);
    test_start_gate_r9();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule